// File: doc/BRIEF.md
# Configurable GPIO bank controller

This block controls a bank of twelve general-purpose pins, each set up through its own configuration word. A pin can be an input or an output, active high or active low, driven both ways or open drain, and it can be forced to high impedance whatever its other settings are. The block produces the pad-side output data and output enable for every pin. It brings each pad input through a two-flop synchroniser and corrects its polarity. It raises a one-cycle event toward an interrupt controller when a pin enabled as an interrupt source goes to its asserted level.

Each pin can also leave its default, register-controlled function and take one of four alternate functions. On an output pin, the alternate function drives the pad from one of four `alt_src` signals supplied by other logic, such as a clock or a status flag. On an input pin, the alternate function feeds the pin's level into one of four `alt_dst` signals for other logic, such as a power-state request or a regulator mode control. The configuration port is a plain register port: a write takes effect on the clock edge, a read is combinational, and there is no back-pressure. The pins carry level signals, not a data stream, so there is no valid/ready handshake.

Top module: `pinbank_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, every configuration word is zero. Every `pad_oe` bit is low, every `irq_evt` bit is low, and reading any pin address returns 0.
- R2: Configuration word bit 0 selects output (1) or input (0). An input pin keeps `pad_oe` low. A push-pull output pin (bit 2 = 0) holds `pad_oe` high and drives `pad_out` to its logical value XOR the polarity bit. With the default function, the logical value is bit 8 of the word.
- R3: With bit 2 set (open drain), an output pin holds `pad_out` low. It raises `pad_oe` only when the pad level it wants is low, and releases the pad otherwise.
- R4: With bit 3 set (forced high impedance), `pad_oe` of that pin is low whatever bits 0, 1, 2, 4 and 8 hold.
- R5: Bit 1 set makes a pin active low. It inverts both the value driven on the pad and the level reported for the pad input.
- R6: Reading address 12 returns, in bits 11:0, each pin's synchronised pad level XOR its polarity bit. A change on `pad_in` set up before clock edge k shows there after edge k+1.
- R7: With bit 7 set, `irq_evt` of a pin is high for exactly one cycle each time its polarity-corrected level goes from 0 to 1. Its rise is seen in the same cycle as the new level in R6. With bit 7 clear, `irq_evt` stays low.
- R8: With bit 4 set, an output pin takes its logical value from `alt_src[sel]`, where sel is bits 6:5, instead of from bit 8.
- R9: Each `alt_dst[k]` is the OR of the polarity-corrected levels of the input pins that have bit 4 set and bits 6:5 equal to k.
- R10: A write with `wr_addr` from 0 to 11 stores `wr_data[8:0]` as that pin's word, and a read of the same address returns it zero-extended. Writes to addresses 12 to 15 change nothing, and reads of addresses 13 to 15 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 4 | Write address (pin index) |
| wr_data | input | 16 | Write data; bits 8:0 form the pin word |
| rd_addr | input | 4 | Read address |
| rd_data | output | 16 | Combinational read data |
| pad_in | input | 12 | Raw pad input levels |
| pad_out | output | 12 | Pad output data |
| pad_oe | output | 12 | Pad output enable |
| irq_evt | output | 12 | One-cycle per-pin interrupt events |
| alt_src | input | 4 | Alternate output sources from other logic |
| alt_dst | output | 4 | Alternate input destinations to other logic |

## Verification
On every cycle, the assertions check the per-pin drive rules: an input pin never drives, a pin forced to high impedance never drives, and an open-drain pin never drives high. They also check that an interrupt event never lasts two cycles and that a write to a pin address lands in that pin's word. The bench compares every output against a behavioural model on every clock. Only that comparison can show the synchroniser latency, the polarity inversion on both paths, alternate-function routing in both directions and the no-effect addresses. The random configurations and pad toggling in the bench reach those cases.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
  localparam int ALT_SEL_W = 2;
  localparam int NUM_ALT   = 1 << ALT_SEL_W;

  typedef struct packed {
    logic                 out_val;
    logic                 irq_en;
    logic [ALT_SEL_W-1:0] alt_sel;
    logic                 alt_en;
    logic                 hiz;
    logic                 odrain;
    logic                 inv;
    logic                 dir_out;
  } pin_cfg_t;

  localparam int CFG_W = $bits(pin_cfg_t);
endpackage

// File: rtl/pinbank_regs.sv
module pinbank_regs
  import pinbank_pkg::*;
#(
  parameter int NUM_PINS = 12,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic [NUM_PINS-1:0] level,
  output logic [DATA_W-1:0]   rd_data,
  output pin_cfg_t            cfg_o [NUM_PINS]
);
  localparam logic [ADDR_W-1:0] LEVEL_ADDR = ADDR_W'(NUM_PINS);

  pin_cfg_t cfg_q [NUM_PINS];

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[i] <= '0;
      end else if (wr_en && wr_addr == ADDR_W'(i)) begin
        cfg_q[i] <= pin_cfg_t'(wr_data[CFG_W-1:0]);
      end
    end
    assign cfg_o[i] = cfg_q[i];

    // R10: a write to this pin's address is stored on the next edge
    assert_write_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(i)) |=> (cfg_q[i] == $past(wr_data[CFG_W-1:0])));
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (rd_addr == ADDR_W'(i)) rd_data = DATA_W'(cfg_q[i]);
    end
    if (rd_addr == LEVEL_ADDR) rd_data = DATA_W'(level);
  end
endmodule

// File: rtl/pinbank_cell.sv
module pinbank_cell
  import pinbank_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  pin_cfg_t           cfg,
  input  logic               pad_in,
  input  logic [NUM_ALT-1:0] alt_src,
  output logic               pad_out,
  output logic               pad_oe,
  output logic               level,
  output logic               irq_evt
);
  logic sync1, sync2, level_prev;
  logic logical_val, pad_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1      <= 1'b0;
      sync2      <= 1'b0;
      level_prev <= 1'b0;
    end else begin
      sync1      <= pad_in;
      sync2      <= sync1;
      level_prev <= level;
    end
  end

  assign level   = sync2 ^ cfg.inv;
  assign irq_evt = cfg.irq_en & level & ~level_prev;

  always_comb begin
    logical_val = cfg.alt_en ? alt_src[cfg.alt_sel] : cfg.out_val;
    pad_val     = logical_val ^ cfg.inv;
    if (!cfg.dir_out || cfg.hiz) begin
      pad_oe  = 1'b0;
      pad_out = cfg.odrain ? 1'b0 : pad_val;
    end else if (cfg.odrain) begin
      pad_oe  = ~pad_val;
      pad_out = 1'b0;
    end else begin
      pad_oe  = 1'b1;
      pad_out = pad_val;
    end
  end

  assert_input_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.dir_out |-> !pad_oe);
  assert_od_never_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.odrain && pad_oe) |-> !pad_out);
  assert_hiz_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.hiz |-> !pad_oe);
  assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_evt |=> !irq_evt);
endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
  import pinbank_pkg::*;
#(
  parameter int NUM_PINS = 12,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [DATA_W-1:0]   rd_data,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] irq_evt,
  input  logic [NUM_ALT-1:0]  alt_src,
  output logic [NUM_ALT-1:0]  alt_dst
);
  pin_cfg_t            cfg [NUM_PINS];
  logic [NUM_PINS-1:0] level;

  pinbank_regs #(
    .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .level(level),
    .rd_data(rd_data), .cfg_o(cfg)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    pinbank_cell u_cell (
      .clk(clk), .rst_n(rst_n), .cfg(cfg[i]), .pad_in(pad_in[i]),
      .alt_src(alt_src), .pad_out(pad_out[i]), .pad_oe(pad_oe[i]),
      .level(level[i]), .irq_evt(irq_evt[i])
    );
  end

  always_comb begin
    alt_dst = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (!cfg[i].dir_out && cfg[i].alt_en && level[i])
        alt_dst[cfg[i].alt_sel] = 1'b1;
    end
  end
endmodule

// File: tb/pinbank_ctrl_bench.sv
`timescale 1ns/1ps
module pinbank_ctrl_bench;
  localparam int NP = 12;
  localparam int NA = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic           rst_n;
  logic           wr_en;
  logic [3:0]     wr_addr;
  logic [15:0]    wr_data;
  logic [3:0]     rd_addr;
  logic [15:0]    rd_data;
  logic [NP-1:0]  pad_in, pad_out, pad_oe, irq_evt;
  logic [NA-1:0]  alt_src, alt_dst;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  pinbank_ctrl u_pinbank_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .irq_evt(irq_evt), .alt_src(alt_src), .alt_dst(alt_dst)
  );

  // behavioural reference state
  logic [8:0]    cfg_m [NP];
  logic [NP-1:0] hist [$];
  logic [NP-1:0] prev_m;

  function automatic logic [NP-1:0] corr_now();
    logic [NP-1:0] r;
    for (int i = 0; i < NP; i++) r[i] = hist[1][i] ^ cfg_m[i][1];
    return r;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      for (int i = 0; i < NP; i++) cfg_m[i] = '0;
      hist = {NP'(0), NP'(0)};
      prev_m = '0;
    end else begin
      prev_m = corr_now();
      if (wr_en && wr_addr < NP) cfg_m[wr_addr] = wr_data[8:0];
      hist.push_front(pad_in);
      if (hist.size() > 3) void'(hist.pop_back());
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  bit compare_on = 0;
  always @(negedge clk) begin
    if (compare_on && rst_n && !done) begin
      logic [NP-1:0] c;
      logic [NA-1:0] edst;
      logic [15:0]   erd;
      c = corr_now();
      edst = '0;
      for (int i = 0; i < NP; i++) begin
        logic dir, inv, od, hz, ae, ie, ov, v, p, eoe, eout, eirq;
        logic [1:0] sel;
        dir = cfg_m[i][0]; inv = cfg_m[i][1]; od = cfg_m[i][2]; hz = cfg_m[i][3];
        ae = cfg_m[i][4]; sel = cfg_m[i][6:5]; ie = cfg_m[i][7]; ov = cfg_m[i][8];
        v = ae ? alt_src[sel] : ov;
        p = v ^ inv;
        eoe = dir & ~hz & (od ? ~p : 1'b1);
        eout = od ? 1'b0 : p;
        eirq = ie & c[i] & ~prev_m[i];
        if (!dir && ae && c[i]) edst[sel] = 1'b1;
        // R4 forced release, R3 open drain, R2 direction
        chk(pad_oe[i] === eoe, hz ? "R4" : (od ? "R3" : "R2"), 32'(pad_oe[i]), 32'(eoe));
        if (dir && !hz && (eoe || !od))
          // R8 alternate output, R5 polarity, R2 plain drive
          chk(pad_out[i] === eout, ae ? "R8" : (inv ? "R5" : "R2"), 32'(pad_out[i]), 32'(eout));
        chk(irq_evt[i] === eirq, "R7", 32'(irq_evt[i]), 32'(eirq));
      end
      chk(alt_dst === edst, "R9", 32'(alt_dst), 32'(edst));
      if (rd_addr < NP) erd = 16'(cfg_m[rd_addr]);
      else if (rd_addr == NP) erd = 16'(c);
      else erd = '0;
      chk(rd_data === erd, rd_addr == NP ? "R6" : "R10", 32'(rd_data), 32'(erd));
    end
  end

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    wait (cycles >= 150000);
    chk(1'b0, "watchdog", 32'(cycles), 32'd0);
    finish_run();
  end

  task automatic wr(int a, logic [8:0] d);
    @(negedge clk); #1;
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr = '0; pad_in = '0; alt_src = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int a = 0; a < NP; a++) begin
      rd_addr = 4'(a); #0.5;
      chk(rd_data === 16'h0, "R1", 32'(rd_data), 32'h0);
    end
    chk(pad_oe === '0, "R1", 32'(pad_oe), 32'h0);
    chk(irq_evt === '0, "R1", 32'(irq_evt), 32'h0);
    #1 rst_n = 1'b1;
    compare_on = 1;
    @(negedge clk);
    chk(pad_oe === '0, "R1", 32'(pad_oe), 32'h0);
    // directed setups: push-pull high, open drain, hiz, inverted, alt out, alt in, irq
    wr(0, 9'h101);
    wr(1, 9'h005);
    wr(2, 9'h10F);
    wr(3, 9'h083);
    wr(4, 9'h031);
    wr(5, 9'h050);
    wr(6, 9'h080);
    wr(13, 9'h1FF);   // R10: ignored address
    for (int k = 0; k < 40; k++) begin
      @(negedge clk); #1;
      pad_in = NP'($urandom);
      alt_src = NA'($urandom);
      rd_addr = 4'(k % 16);
    end
    // random phase
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk); #1;
      for (int i = 0; i < NP; i++) if ($urandom_range(3) == 0) pad_in[i] = ~pad_in[i];
      if ($urandom_range(2) == 0) alt_src = NA'($urandom);
      rd_addr = 4'($urandom_range(15));
      if ($urandom_range(9) == 0) begin
        wr_en = 1'b1; wr_addr = 4'($urandom_range(15)); wr_data = 16'($urandom);
      end else begin
        wr_en = 1'b0;
      end
    end
    @(negedge clk); #1 wr_en = 1'b0;
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule